// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block sits between a processor's register bus and a nonvolatile memory array and turns software register writes into timed array operations. Software first loads a target address and a data word into two holding registers. It then writes a control register. That write must carry an unlock key in its upper half, and the low four bits choose one of four operations: program one word, erase a page, erase the whole main array, or commit a register value to nonvolatile storage. A keyed write that selects exactly one operation captures the address and data, sends a one-cycle request to the array model, and marks that operation busy until the model reports completion.

The array model inside the block is behavioural. It holds no cell contents and stands in for the real timing. Each operation takes a number of clock cycles set by its own parameter. While an operation is in flight, all bus writes are dropped, so the operation cannot be disturbed. A keyed write that selects more than one operation is refused and raises an error flag. The next command that is accepted clears that flag. When an operation ends, a one-cycle completion pulse is produced that can serve as an interrupt source.

Control is a four-state machine. `S_IDLE` waits for a command. `S_IDLE -> S_REQ` happens on an accepted command. `S_REQ -> S_WAIT` always follows one cycle later, carrying the request pulse. `S_WAIT -> S_DONE` happens when the array model reports done. `S_DONE -> S_IDLE` always follows one cycle later and carries the completion pulse.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: A control write (wr_sel = 2) takes effect only when wr_data[31:16] equals 16'hA442. Any other key leaves the busy bits, the error flag and the completion pulse unchanged.
- R2: A control read returns zero in bits 31:4 whatever was written there. Bits 15:4 are reserved: setting them alongside a valid command does not change the command.
- R3: Control bit 0 selects word program, bit 1 page erase, bit 2 mass erase and bit 3 commit. fl_op carries the same index (0 to 3), and at most one busy bit is set at a time.
- R4: The selected busy bit reads 1 from the cycle after the accepted write for exactly DURATION+2 cycles, then reads 0.
- R5: A keyed control write with all four command bits at zero changes nothing, whether the block is idle or busy.
- R6: A keyed write with two or more command bits set, made while idle, starts nothing and sets cmd_err. The next accepted command clears cmd_err.
- R7: The address (wr_sel = 0) and data (wr_sel = 1) registers are captured when a command is accepted. fl_addr and fl_wdata present the captured values and do not change while the operation runs.
- R8: While any operation is busy, writes to the address, data and control registers are ignored.
- R9: done_pulse is high for exactly one cycle per operation, in the last cycle in which the busy bit reads 1.
- R10: Each operation's duration comes from its own parameter (T_PROG, T_PERASE, T_MERASE, T_COMMIT), so a mass erase stays busy longer than a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 address, 1 data, 2 control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target: 0 address, 1 data, 2 control |
| rd_data | output | 32 | Read data (combinational) |
| fl_req | output | 1 | One-cycle operation request to the array |
| fl_op | output | 2 | Operation index of the request in flight |
| fl_addr | output | AW | Captured target address |
| fl_wdata | output | DW | Captured program data |
| done_pulse | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Set by a refused multi-bit command |

## Verification
The bench goes after the key check with near-miss and zero keys. A design that compares too few key bits would start an operation there. It writes the address, data and control registers mid-operation and checks that the captured values and busy bits stay put; a design with no lock would move fl_addr, or start a second operation and produce a second completion pulse. It counts the busy cycles of each operation against its own parameter, which catches swapped durations or an off-by-one counter. It also covers multi-bit commands, zero-command writes and writes with the reserved bits set. A design that got these wrong would start an operation, leave cmd_err in the wrong state, or echo the written bits on readback.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
    localparam int NUM_OPS = 4;
    localparam logic [15:0] UNLOCK_KEY = 16'hA442;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_PERASE = 2'd1,
        OP_MERASE = 2'd2,
        OP_COMMIT = 2'd3
    } nvm_op_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2,
        S_DONE = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
    import nvm_cmd_pkg::*;
#(
    parameter logic [15:0] KEY = UNLOCK_KEY
) (
    input  logic [31:0] wdata,
    output logic        key_ok,
    output logic        single,
    output logic        multi,
    output nvm_op_e     op
);
    logic [NUM_OPS-1:0] cmd;
    int                 ones;

    always_comb begin
        key_ok = (wdata[31:16] == KEY);
        cmd    = wdata[NUM_OPS-1:0];
        ones   = $countones(cmd);
        single = (ones == 1);
        multi  = (ones > 1);
        op     = OP_PROG;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (cmd[i]) op = nvm_op_e'(2'(i));
        end
    end
endmodule

// File: rtl/nvm_cmd_regs.sv
module nvm_cmd_regs
    import nvm_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          lock,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_en && !lock) begin
            if (reg_sel_e'(wr_sel) == SEL_ADDR) addr_q <= wr_data[AW-1:0];
            if (reg_sel_e'(wr_sel) == SEL_DATA) data_q <= wr_data[DW-1:0];
        end
    end

    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(addr_q)); // R8
    AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(data_q)); // R8
endmodule

// File: rtl/nvm_flash_stub.sv
module nvm_flash_stub
    import nvm_cmd_pkg::*;
#(
    parameter int T_PROG   = 3,
    parameter int T_PERASE = 5,
    parameter int T_MERASE = 12,
    parameter int T_COMMIT = 7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req,
    input  nvm_op_e op,
    output logic    done
);
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAXD = max2(max2(T_PROG, T_PERASE), max2(T_MERASE, T_COMMIT));
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] dur;
    logic          active;

    always_comb begin
        unique case (op)
            OP_PROG:   dur = CW'(T_PROG);
            OP_PERASE: dur = CW'(T_PERASE);
            OP_MERASE: dur = CW'(T_MERASE);
            OP_COMMIT: dur = CW'(T_COMMIT);
        endcase
        active = (cnt != '0);
        done   = (cnt == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (req)        cnt <= dur;
        else if (active)     cnt <= cnt - CW'(1);
    end

    AST_STUB_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !active); // R4
    AST_STUB_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active); // R10
endmodule

// File: rtl/nvm_cmd_fsm.sv
module nvm_cmd_fsm
    import nvm_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_multi,
    input  nvm_op_e            cmd_op,
    input  logic [AW-1:0]      addr_in,
    input  logic [DW-1:0]      data_in,
    input  logic               stub_done,
    output logic               fl_req,
    output nvm_op_e            fl_op,
    output logic [AW-1:0]      fl_addr,
    output logic [DW-1:0]      fl_wdata,
    output logic [NUM_OPS-1:0] busy_bits,
    output logic               busy,
    output logic               done_pulse,
    output logic               cmd_err
);
    ctl_state_e    state, state_nx;
    nvm_op_e       cur_op;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic          accept;

    assign accept = cmd_valid && (state == S_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept)    state_nx = S_REQ;
            S_REQ:                 state_nx = S_WAIT;
            S_WAIT: if (stub_done) state_nx = S_DONE;
            S_DONE:                state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op   <= OP_PROG;
            cap_addr <= '0;
            cap_data <= '0;
            cmd_err  <= 1'b0;
        end else if (state == S_IDLE) begin
            if (accept) begin
                cur_op   <= cmd_op;
                cap_addr <= addr_in;
                cap_data <= data_in;
                cmd_err  <= 1'b0;
            end else if (cmd_multi) begin
                cmd_err  <= 1'b1;
            end
        end
    end

    always_comb begin
        fl_req     = (state == S_REQ);
        done_pulse = (state == S_DONE);
        busy       = (state != S_IDLE);
        busy_bits  = busy ? (NUM_OPS'(1) << cur_op) : '0;
        fl_op      = cur_op;
        fl_addr    = cap_addr;
        fl_wdata   = cap_data;
    end

    AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_bits)); // R3
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |=> !fl_req); // R4
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT || state == S_DONE) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R7
    AST_DONE_AFTER_STUB: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(stub_done)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R9
    AST_ERR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_err) || !$past(busy)); // R8
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int T_PROG   = 3,
    parameter int T_PERASE = 5,
    parameter int T_MERASE = 12,
    parameter int T_COMMIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic [1:0]    rd_sel,
    output logic [31:0]   rd_data,
    output logic          fl_req,
    output logic [1:0]    fl_op,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          done_pulse,
    output logic          cmd_err
);
    logic               key_ok, single, multi, busy, stub_done;
    logic               ctrl_wr, cmd_valid, cmd_multi;
    nvm_op_e            dec_op, op_q;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      data_q;
    logic [NUM_OPS-1:0] busy_bits;

    nvm_cmd_decode #(.KEY(UNLOCK_KEY)) u_dec (
        .wdata(wr_data), .key_ok(key_ok), .single(single), .multi(multi), .op(dec_op)
    );

    assign ctrl_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL) && key_ok;
    assign cmd_valid = ctrl_wr && single;
    assign cmd_multi = ctrl_wr && multi;

    nvm_cmd_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lock(busy), .addr_q(addr_q), .data_q(data_q)
    );

    nvm_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_multi(cmd_multi),
        .cmd_op(dec_op), .addr_in(addr_q), .data_in(data_q), .stub_done(stub_done),
        .fl_req(fl_req), .fl_op(op_q), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .busy_bits(busy_bits), .busy(busy), .done_pulse(done_pulse), .cmd_err(cmd_err)
    );

    nvm_flash_stub #(
        .T_PROG(T_PROG), .T_PERASE(T_PERASE), .T_MERASE(T_MERASE), .T_COMMIT(T_COMMIT)
    ) u_stub (
        .clk(clk), .rst_n(rst_n), .req(fl_req), .op(op_q), .done(stub_done)
    );

    assign fl_op = op_q;

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_ADDR: rd_data[AW-1:0]      = addr_q;
            SEL_DATA: rd_data[DW-1:0]      = data_q;
            SEL_CTRL: rd_data[NUM_OPS-1:0] = busy_bits;
            SEL_NONE: rd_data              = '0;
        endcase
    end
endmodule

// File: tb/nvm_cmd_ctrl_bench.sv
module nvm_cmd_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TP = 3, TE = 5, TM = 12, TC = 7;
    localparam logic [31:0] KEY = 32'hA442_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd3;
    logic [31:0]   wr_data = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [31:0]   rd_data;
    logic          fl_req, done_pulse, cmd_err;
    logic [1:0]    fl_op;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;

    int errors = 0, checks = 0, done_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nvm_cmd_ctrl #(.AW(AW), .DW(DW), .T_PROG(TP), .T_PERASE(TE), .T_MERASE(TM), .T_COMMIT(TC))
    u_nvm_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .fl_req(fl_req), .fl_op(fl_op),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .done_pulse(done_pulse), .cmd_err(cmd_err)
    );

    always @(negedge clk) if (rst_n && done_pulse) done_cnt++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk(v == 0, "R2 reset addr", v, 0);
        rd(2'd2, v); chk(v == 0, "R2 reset ctrl", v, 0);
        chk({fl_req, done_pulse, cmd_err} == 0, "R9 reset outputs", {fl_req, done_pulse, cmd_err}, 0);
    endtask

    task automatic t_bad_key(input logic [15:0] key);
        logic [31:0] v;
        int d0 = done_cnt;
        bus_wr(2'd2, {key, 16'h0001});
        rd(2'd2, v); chk(v == 0, "R1 bad key busy", v, 0);
        chk(cmd_err == 0, "R1 bad key err", cmd_err, 0);
        repeat (TP + 3) @(negedge clk);
        chk(done_cnt == d0, "R1 bad key no completion", done_cnt, d0);
    endtask

    task automatic run_op(input int op, input int dur, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [11:0] resv);
        logic [31:0] v;
        int n = 0, d0 = done_cnt;
        bit held = 1;
        bus_wr(2'd0, 32'(a));
        bus_wr(2'd1, d);
        bus_wr(2'd2, KEY | {16'h0, resv, 4'h0} | (32'd1 << op));
        rd(2'd2, v);
        chk(v == (32'd1 << op), "R2 R3 ctrl readback busy bit", v, 32'd1 << op);
        chk(fl_op == 2'(op), "R3 fl_op index", 32'(fl_op), op);
        while (v != 0 && n < 100) begin
            n++;
            if (fl_addr != a || fl_wdata != d) held = 0;
            @(negedge clk);
            rd(2'd2, v);
        end
        chk(n == dur + 2, "R4 R10 busy cycles", n, dur + 2);
        chk(held, "R7 captured addr/data held", {fl_addr, 16'h0}, {a, 16'h0});
        chk(done_cnt == d0 + 1, "R9 one completion", done_cnt, d0 + 1);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        int d0 = done_cnt;
        bus_wr(2'd0, 32'h0000_1111);
        bus_wr(2'd1, 32'hCAFE_0001);
        bus_wr(2'd2, KEY | 32'h4);
        bus_wr(2'd0, 32'h0000_2222);
        bus_wr(2'd1, 32'hBEEF_0002);
        bus_wr(2'd2, KEY | 32'h1);
        bus_wr(2'd2, KEY);
        rd(2'd0, v); chk(v == 32'h1111, "R8 addr locked", v, 32'h1111);
        rd(2'd1, v); chk(v == 32'hCAFE_0001, "R8 data locked", v, 32'hCAFE_0001);
        rd(2'd2, v); chk(v == 32'h4, "R5 R8 busy bit kept", v, 32'h4);
        chk(fl_addr == 16'h1111, "R7 fl_addr during lock", 32'(fl_addr), 32'h1111);
        repeat (TM + 4) @(negedge clk);
        rd(2'd2, v); chk(v == 0, "R4 idle after mass erase", v, 0);
        chk(done_cnt == d0 + 1, "R8 no second operation", done_cnt, d0 + 1);
        rd(2'd0, v); chk(v == 32'h1111, "R8 addr after op", v, 32'h1111);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        bus_wr(2'd2, KEY | 32'h3);
        rd(2'd2, v); chk(v == 0, "R6 multi no busy", v, 0);
        chk(cmd_err == 1, "R6 multi sets err", cmd_err, 1);
        bus_wr(2'd2, KEY);
        chk(cmd_err == 1, "R5 zero write keeps err", cmd_err, 1);
        rd(2'd2, v); chk(v == 0, "R5 zero write idle", v, 0);
        bus_wr(2'd2, KEY | 32'h8);
        chk(cmd_err == 0, "R6 accept clears err", cmd_err, 0);
        repeat (TC + 4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_key(16'hA443);
        t_bad_key(16'h0000);
        run_op(0, TP, 16'h00A5, 32'h1234_5678, 12'h000);
        run_op(1, TE, 16'h0400, 32'h0, 12'h000);
        run_op(2, TM, 16'h0000, 32'h0, 12'h000);
        run_op(3, TC, 16'h7FFE, 32'hDEAD_BEEF, 12'h000);
        run_op(0, TP, 16'hFFFF, 32'hA5A5_5A5A, 12'hFFF);
        t_lock();
        t_multi();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule